// File: doc/BRIEF.md
# Audio master clock divider

This block derives the master clock of a serial audio block from a kernel clock. A small divide code sets the ratio. Code zero passes the kernel clock straight through. Any other code N divides the kernel clock by 2×N and gives a 50% duty cycle. A bypass flag forces the pass-through path whatever the code is.

When the audio block is a clock slave, or when it is disabled, the block stays silent. The configuration (code, bypass flag and master/slave flag) is sampled only on kernel clock edges where the enable input is low. Changes made while the audio block runs have no effect until it is disabled again.

Alongside the master clock the block gives a one-kernel-cycle strobe. The strobe is high in the cycle where the generated clock goes high, so bit-clock and frame logic can run on the kernel clock with a clock enable instead of on a derived clock. In pass-through mode every kernel cycle holds a rising edge, so the strobe stays high.

Top module: `audmclk_gen`

## Requirements
- R1: While rstN is low, mclkOut and mclkRiseStb are 0, whatever the other inputs are.
- R2: With the latched code equal to 0, the master flag 1 and the block enabled, from the first kernel edge after enable onward mclkOut equals the kernel clock level and mclkRiseStb is 1 in every cycle.
- R3: With a latched nonzero code N, no bypass, the master flag 1 and the block enabled, mclkOut is a clock with a period of 2×N kernel cycles, high for N cycles and low for N. After the k-th kernel edge following enable, mclkOut equals (k / N) mod 2 (integer division).
- R4: In divided mode mclkRiseStb is 1 for exactly one kernel cycle, the cycle in which mclkOut has just gone high (after edge k with k mod 2N equal to N), and it is 0 in all other cycles.
- R5: With the bypass flag noDiv latched as 1 (master, enabled), the output behaves as in R2 for any divide code.
- R6: The kernel edge that sees blockEn low forces mclkOut and mclkRiseStb to 0 and resets the divider phase. On re-enable the count restarts as in R3, with edge 1 as the first edge after enable.
- R7: With isMaster latched as 0, mclkOut and mclkRiseStb stay 0, and the divide code and the bypass flag have no effect.
- R8: divCode, noDiv and isMaster are taken only on kernel edges where blockEn is low. Changes while blockEn is high do not alter the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkKer | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divCode | input | CODE_W (4) | Divide code: 0 passes the clock through, N divides by 2×N |
| noDiv | input | 1 | Bypass flag: 1 forces the pass-through path |
| isMaster | input | 1 | 1 when the audio block is a clock master |
| blockEn | input | 1 | Audio block enable status |
| mclkOut | output | 1 | Generated master clock |
| mclkRiseStb | output | 1 | One-cycle strobe on each rising edge of mclkOut |

## Verification
The bench builds the block with the default code width of 4. This puts every ratio within reach, from pass-through up to the largest code of 15 (a 30-cycle period), so the terminal count at the top of the counter range and the code-1 case are both exercised. A 64-cycle window per vector spans more than two full periods even at the slowest ratio, which exposes duty-cycle, phase-origin and strobe-spacing errors. Directed runs then change the configuration while enabled, disable in the middle of a period and re-enable, to show that the latch holds and the phase restarts.

// File: rtl/audmclk_pkg.sv
package audmclk_pkg;

  // Strobes sent from the control unit to the divider datapath
  typedef struct packed {
    logic run;       // block enabled and configured as master
    logic passMode;  // kernel clock passed through undivided
  } ctrlStb_t;

endpackage

// File: rtl/audmclk_ctrl.sv
module audmclk_ctrl
  import audmclk_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clkKer,
  input  logic              rstN,
  input  logic [CODE_W-1:0] divCode,
  input  logic              noDiv,
  input  logic              isMaster,
  input  logic              blockEn,
  output ctrlStb_t          ctrlStb,
  output logic [CODE_W-1:0] termCnt
);

  logic [CODE_W-1:0] cfgCodeQ;
  logic              cfgNoDivQ;
  logic              cfgMasterQ;

  // Configuration is only accepted while the audio block is disabled
  always_ff @(posedge clkKer or negedge rstN) begin
    if (!rstN) begin
      cfgCodeQ   <= '0;
      cfgNoDivQ  <= 1'b0;
      cfgMasterQ <= 1'b0;
    end else if (!blockEn) begin
      cfgCodeQ   <= divCode;
      cfgNoDivQ  <= noDiv;
      cfgMasterQ <= isMaster;
    end
  end

  always_comb begin
    ctrlStb.run      = blockEn & cfgMasterQ;
    ctrlStb.passMode = cfgNoDivQ | (cfgCodeQ == '0);
    termCnt          = cfgCodeQ - CODE_W'(1);
  end

endmodule

// File: rtl/audmclk_dp.sv
module audmclk_dp
  import audmclk_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clkKer,
  input  logic              rstN,
  input  ctrlStb_t          ctrlStb,
  input  logic [CODE_W-1:0] termCnt,
  output logic              mclkOut,
  output logic              mclkRiseStb
);

  logic [CODE_W-1:0] cntQ;
  logic              divClkQ;
  logic              stbQ;
  logic              passEnQ;

  // Half-period counter: toggles the divided clock every termCnt+1 edges
  always_ff @(posedge clkKer or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      divClkQ <= 1'b0;
      stbQ    <= 1'b0;
    end else if (!ctrlStb.run || ctrlStb.passMode) begin
      cntQ    <= '0;
      divClkQ <= 1'b0;
      stbQ    <= 1'b0;
    end else if (cntQ == termCnt) begin
      cntQ    <= '0;
      divClkQ <= ~divClkQ;
      stbQ    <= ~divClkQ;
    end else begin
      cntQ    <= cntQ + CODE_W'(1);
      stbQ    <= 1'b0;
    end
  end

  // Registered gate for the pass-through path
  always_ff @(posedge clkKer or negedge rstN) begin
    if (!rstN) passEnQ <= 1'b0;
    else       passEnQ <= ctrlStb.run & ctrlStb.passMode;
  end

  assign mclkOut     = passEnQ ? clkKer : divClkQ;
  assign mclkRiseStb = passEnQ | stbQ;

endmodule

// File: rtl/audmclk_gen.sv
module audmclk_gen
  import audmclk_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clkKer,
  input  logic              rstN,
  input  logic [CODE_W-1:0] divCode,
  input  logic              noDiv,
  input  logic              isMaster,
  input  logic              blockEn,
  output logic              mclkOut,
  output logic              mclkRiseStb
);

  ctrlStb_t          ctrlStb;
  logic [CODE_W-1:0] termCnt;

  audmclk_ctrl #(.CODE_W(CODE_W)) ctrlI (
    .clkKer   (clkKer),
    .rstN     (rstN),
    .divCode  (divCode),
    .noDiv    (noDiv),
    .isMaster (isMaster),
    .blockEn  (blockEn),
    .ctrlStb  (ctrlStb),
    .termCnt  (termCnt)
  );

  audmclk_dp #(.CODE_W(CODE_W)) dpI (
    .clkKer      (clkKer),
    .rstN        (rstN),
    .ctrlStb     (ctrlStb),
    .termCnt     (termCnt),
    .mclkOut     (mclkOut),
    .mclkRiseStb (mclkRiseStb)
  );

endmodule

// File: rtl/audmclk_chk.sv
module audmclk_chk #(
  parameter int CODE_W = 4
) (
  input logic              clkKer,
  input logic              rstN,
  input logic              blockEn,
  input logic              mclkRiseStb,
  input logic [CODE_W-1:0] cfgCode,
  input logic              cfgMaster,
  input logic              divClk,
  input logic              stbDiv
);

  // R6: a disabled block drives no strobe and no divided clock next cycle
  assert_idle_low_R6: assert property (@(posedge clkKer) disable iff (!rstN)
    !blockEn |=> (!mclkRiseStb && !divClk));

  // R7: slave configuration never produces a strobe
  assert_slave_quiet_R7: assert property (@(posedge clkKer) disable iff (!rstN)
    !cfgMaster |=> !mclkRiseStb);

  // R8: latched code does not move while enabled
  assert_cfg_hold_R8: assert property (@(posedge clkKer) disable iff (!rstN)
    blockEn |=> $stable(cfgCode));

  // R4: divided-mode strobe lasts a single kernel cycle
  assert_stb_single_R4: assert property (@(posedge clkKer) disable iff (!rstN)
    stbDiv |=> !stbDiv);

  // R4: every rise of the divided clock comes with the strobe
  assert_rise_stb_R4: assert property (@(posedge clkKer) disable iff (!rstN)
    $rose(divClk) |-> stbDiv);

  // R3: strobe only while the divided clock is high
  assert_stb_high_R3: assert property (@(posedge clkKer) disable iff (!rstN)
    stbDiv |-> divClk);

endmodule

bind audmclk_gen audmclk_chk #(.CODE_W(CODE_W)) chkI (
  .clkKer      (clkKer),
  .rstN        (rstN),
  .blockEn     (blockEn),
  .mclkRiseStb (mclkRiseStb),
  .cfgCode     (ctrlI.cfgCodeQ),
  .cfgMaster   (ctrlI.cfgMasterQ),
  .divClk      (dpI.divClkQ),
  .stbDiv      (dpI.stbQ)
);

// File: tb/audmclk_gen_tb_top.sv
module audmclk_gen_tb_top;

  localparam int CODE_W = 4;
  localparam int WIN    = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CODE_W-1:0] divCode = 4'd1;
  logic              noDiv = 1'b0;
  logic              isMaster = 1'b1;
  logic              blockEn = 1'b1;
  logic              mclkOut;
  logic              mclkRiseStb;

  int errCnt = 0;
  int chkCnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  audmclk_gen #(.CODE_W(CODE_W)) dut_i (
    .clkKer      (clk),
    .rstN        (rstN),
    .divCode     (divCode),
    .noDiv       (noDiv),
    .isMaster    (isMaster),
    .blockEn     (blockEn),
    .mclkOut     (mclkOut),
    .mclkRiseStb (mclkRiseStb)
  );

  // Vector: {code[3:0], noDiv, isMaster, kind[1:0], half[3:0]}
  // kind 0 = silent, 1 = pass-through, 2 = divided with half-period half
  localparam logic [11:0] VEC [9] = '{
    {4'd0,  1'b0, 1'b1, 2'd1, 4'd0},   // R2
    {4'd1,  1'b0, 1'b1, 2'd2, 4'd1},   // R3
    {4'd2,  1'b0, 1'b1, 2'd2, 4'd2},   // R3
    {4'd3,  1'b0, 1'b1, 2'd2, 4'd3},   // R3
    {4'd7,  1'b0, 1'b1, 2'd2, 4'd7},   // R3
    {4'd15, 1'b0, 1'b1, 2'd2, 4'd15},  // R3 top code
    {4'd5,  1'b1, 1'b1, 2'd1, 4'd0},   // R5
    {4'd4,  1'b0, 1'b0, 2'd0, 4'd0},   // R7
    {4'd0,  1'b1, 1'b0, 2'd0, 4'd0}    // R7 bypass ignored
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Walks edges j0..j0+n-1 after enable, comparing both clock phases
  task automatic runWin(input int kind, input int half, input int j0, input int n,
                        output int bad, output int rises, output int expRises);
    bad = 0; rises = 0; expRises = 0;
    for (int j = j0; j < j0 + n; j++) begin
      logic expHi, expLo, expStb;
      @(posedge clk); #1;
      case (kind)
        1:       begin expHi = 1'b1; expLo = 1'b0; expStb = 1'b1; end
        2:       begin
                   expHi  = ((j / half) % 2) == 1;
                   expLo  = expHi;
                   expStb = (j % (2 * half)) == half;
                 end
        default: begin expHi = 1'b0; expLo = 1'b0; expStb = 1'b0; end
      endcase
      if (mclkOut !== expHi || mclkRiseStb !== expStb) bad++;
      if (mclkRiseStb === 1'b1) rises++;
      if (expStb) expRises++;
      @(negedge clk); #1;
      if (mclkOut !== expLo) bad++;
    end
  endtask

  task automatic cfgAndEnable(input logic [CODE_W-1:0] c, input logic nd, input logic m);
    blockEn  = 1'b0;
    divCode  = c;
    noDiv    = nd;
    isMaster = m;
    @(posedge clk);
    @(negedge clk); #1;
    blockEn = 1'b1;
  endtask

  initial begin
    int bad, rises, expR;
    // R1: reset holds outputs low even with an enabled master config
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check(mclkOut === 1'b0 && mclkRiseStb === 1'b0, "R1 reset high phase",
            {mclkOut, mclkRiseStb}, 0);
      @(negedge clk); #1;
      check(mclkOut === 1'b0, "R1 reset low phase", mclkOut, 0);
    end
    blockEn = 1'b0;
    rstN = 1'b1;

    // Table walk
    for (int v = 0; v < 9; v++) begin
      logic [11:0] e;
      e = VEC[v];
      cfgAndEnable(e[11:8], e[7], e[6]);
      runWin(int'(e[5:4]), int'(e[3:0]), 1, WIN, bad, rises, expR);
      check(bad == 0, $sformatf("R2/R3/R5/R7 waveform vec%0d", v), bad, 0);
      check(rises == expR, $sformatf("R4 strobe count vec%0d", v), rises, expR);
    end

    // R8: config change while enabled is ignored
    cfgAndEnable(4'd2, 1'b0, 1'b1);
    runWin(2, 2, 1, 6, bad, rises, expR);
    check(bad == 0, "R8 before change", bad, 0);
    divCode = 4'd5; noDiv = 1'b1; isMaster = 1'b0;
    runWin(2, 2, 7, 20, bad, rises, expR);
    check(bad == 0, "R8 change while enabled ignored", bad, 0);
    check(rises == expR, "R8 strobe count after change", rises, expR);

    // R6: disable mid-run, outputs low at next edge
    blockEn = 1'b0;
    runWin(0, 0, 1, 4, bad, rises, expR);
    check(bad == 0, "R6 disabled outputs low", bad, 0);

    // R6: re-enable restarts phase from edge 1
    cfgAndEnable(4'd2, 1'b0, 1'b1);
    runWin(2, 2, 1, 3, bad, rises, expR);
    check(bad == 0, "R6 phase restart", bad, 0);
    check(rises == 1, "R6 first rise at edge 2", rises, 1);

    // R5: bypass with top code
    cfgAndEnable(4'd15, 1'b1, 1'b1);
    runWin(1, 0, 1, 8, bad, rises, expR);
    check(bad == 0, "R5 bypass with code 15", bad, 0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule